// File: doc/BRIEF.md
# Synchronous Byte-Write SRAM Controller

This block holds the per-cycle control and a small behavioural storage array for a 32-bit synchronous SRAM whose data pins are shared between reads and writes. At every rising clock edge it looks at three chip enables, two address strobes and the write qualifiers. From these it decides whether the cycle is a read, a write, a deselect or nothing. Writes can cover any subset of the four byte lanes.

The word address comes from a separate burst sequencer and is used as presented in each cycle. An access opened by the processor strobe always reads in its first cycle and takes its write qualifiers one cycle late. An access opened by the controller strobe acts on its write qualifiers at once.

The output driver is switched off by the asynchronous output enable. It is also switched off after every write, and while the block is idle or deselected. A snooze input freezes the block and keeps the stored data.

Top module: `sbw_sram_ctl`

## Requirements
- R1: The chip counts as selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at the clock edge. A valid strobe seen while the chip is not selected ends the access, writes nothing, and turns the driver off after that edge.
- R2: A processor-strobe start (`adsp_n`=0 and selected) is always a read of `addr` in that cycle, whatever the write inputs are.
- R3: In the cycle after a processor-strobe start, with no new strobe, active write inputs write `dq_in` to `addr` at that edge.
- R4: A controller-strobe start (`adsc_n`=0, `adsp_n`=1, selected) writes at once if the write inputs are active, and reads otherwise.
- R5: With `gw_n`=0 a write covers all four bytes, whatever `bwe_n` and `bsel_n` are.
- R6: With `gw_n`=1 and `bwe_n`=0, `bsel_n[i]`=0 enables byte lane i, which is data bits 8i+7 down to 8i. The other lanes keep their contents.
- R7: After a read edge, `dq_out` holds the word stored at the `addr` sampled at that edge.
- R8: `dq_oe` is low whenever `oe_n`=1, with no clock edge needed.
- R9: After a write edge, `dq_oe` is low whatever `oe_n` is.
- R10: While `snooze`=1 at an edge, all other inputs are ignored: `dq_out`, the driver state and the array keep their values.
- R11: With `gw_n`=1 and either `bwe_n`=1 or all `bsel_n` high, an access cycle is a read.
- R12: A processor strobe with `ce1_n`=1 is ignored. If no access is open, the driver stays off.
- R13: After reset `dq_oe`=0, `dq_out`=0 and no access is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| snooze | input | 1 | Low-power hold, active high |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Byte lane selects, active low |
| addr | input | AW | Word address from the burst sequencer |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 32 | Write data from the shared bus |
| dq_out | output | 32 | Read data register |
| dq_oe | output | 1 | Output driver enable for the shared bus |

## Verification
A stuck or wrongly cleared access flag shows at the ports in the next cycle. A continuation cycle either turns the driver on when it should not, or leaves it off. A wrong lane mask or a write taken in the first processor-strobe cycle does not show until that address is read again, which is one edge later on `dq_out`. For that reason the stimulus reads back written locations often, and it compares every cycle against a shadow copy of the array.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int NBYTES = 4;
    localparam int DW     = 8 * NBYTES;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_DESEL = 2'd3
    } op_e;

    typedef struct packed {
        logic              ce1_n;
        logic              ce2;
        logic              ce3_n;
        logic              adsp_n;
        logic              adsc_n;
        logic              gw_n;
        logic              bwe_n;
        logic [NBYTES-1:0] bsel_n;
    } ctl_s;

    function automatic logic chip_sel(input ctl_s c);
        return !c.ce1_n && c.ce2 && !c.ce3_n;
    endfunction

    // Global write wins over the byte qualifiers.
    function automatic logic [NBYTES-1:0] lane_mask(input ctl_s c);
        if (!c.gw_n)
            return {NBYTES{1'b1}};
        else if (!c.bwe_n)
            return ~c.bsel_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
    import sbw_pkg::*;
(
    input  ctl_s              ctl,
    input  logic              snooze,
    input  logic              active,
    output op_e               op,
    output logic [NBYTES-1:0] lanes,
    output logic              active_nxt,
    output logic              p_start
);
    logic             sel;
    logic             p_valid;
    logic             c_valid;
    logic [NBYTES-1:0] lm;
    logic             wreq;

    always_comb begin
        sel        = chip_sel(ctl);
        p_valid    = !ctl.adsp_n && !ctl.ce1_n;
        c_valid    = !ctl.adsc_n;
        lm         = lane_mask(ctl);
        wreq       = |lm;
        op         = OP_NOP;
        active_nxt = active;
        p_start    = 1'b0;
        if (snooze) begin
            op = OP_NOP;
        end else if ((p_valid || c_valid) && !sel) begin
            op         = OP_DESEL;
            active_nxt = 1'b0;
        end else if (p_valid) begin
            op         = OP_READ;
            active_nxt = 1'b1;
            p_start    = 1'b1;
        end else if (c_valid) begin
            op         = wreq ? OP_WRITE : OP_READ;
            active_nxt = 1'b1;
        end else if (active) begin
            op = wreq ? OP_WRITE : OP_READ;
        end
        lanes = (op == OP_WRITE) ? lm : '0;
    end
endmodule

// File: rtl/sbw_array.sv
module sbw_array
    import sbw_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  logic [NBYTES-1:0] we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (we[i])
                mem[addr] <= wdata[8*i +: 8];
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (re)
                q <= mem[addr];
        end

        assign rdata[8*i +: 8] = q;
    end
endmodule

// File: rtl/sbw_outctl.sv
module sbw_outctl
    import sbw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  op_e  op,
    input  logic oe_n,
    output logic drive_q,
    output logic dq_oe
);
    always_ff @(posedge clk) begin
        if (rst)
            drive_q <= 1'b0;
        else if (!hold)
            drive_q <= (op == OP_READ);
    end

    assign dq_oe = drive_q && !oe_n;
endmodule

// File: rtl/sbw_sram_ctl.sv
module sbw_sram_ctl
    import sbw_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snooze,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bsel_n,
    input  logic [AW-1:0]     addr,
    input  logic              oe_n,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe
);
    ctl_s              ctl;
    op_e               op;
    logic [NBYTES-1:0] we_lanes;
    logic              active;
    logic              active_nxt;
    logic              p_start;
    logic              drive_q;

    assign ctl = '{ce1_n: ce1_n, ce2: ce2, ce3_n: ce3_n, adsp_n: adsp_n,
                   adsc_n: adsc_n, gw_n: gw_n, bwe_n: bwe_n, bsel_n: bsel_n};

    sbw_decode u_dec (
        .ctl        (ctl),
        .snooze     (snooze),
        .active     (active),
        .op         (op),
        .lanes      (we_lanes),
        .active_nxt (active_nxt),
        .p_start    (p_start)
    );

    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else
            active <= active_nxt;
    end

    sbw_array #(.AW(AW)) u_arr (
        .clk   (clk),
        .rst   (rst),
        .re    (op == OP_READ),
        .we    (we_lanes),
        .addr  (addr),
        .wdata (dq_in),
        .rdata (dq_out)
    );

    sbw_outctl u_out (
        .clk     (clk),
        .rst     (rst),
        .hold    (snooze),
        .op      (op),
        .oe_n    (oe_n),
        .drive_q (drive_q),
        .dq_oe   (dq_oe)
    );
endmodule

// File: rtl/sbw_sram_ctl_chk.sv
module sbw_sram_ctl_chk
    import sbw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              snooze,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic              active,
    input logic              p_start,
    input op_e               op,
    input logic [NBYTES-1:0] we_lanes,
    input logic [DW-1:0]     dq_out,
    input logic              dq_oe
);
    logic selected;
    assign selected = !ce1_n && ce2 && !ce3_n;

    p_desel_nowrite_r1: assert property (@(posedge clk) disable iff (rst)
        (!snooze && (!adsc_n || (!adsp_n && !ce1_n)) && !selected) |-> (we_lanes == '0))
        else $error("R1: write during deselect");

    p_desel_drive_off_r1: assert property (@(posedge clk) disable iff (rst)
        (!snooze && (!adsc_n || (!adsp_n && !ce1_n)) && !selected) |=> !dq_oe)
        else $error("R1: driver on after deselect");

    p_pstart_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
        p_start |-> (we_lanes == '0))
        else $error("R2: write in first processor-strobe cycle");

    p_gw_all_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE && !gw_n) |-> (we_lanes == {NBYTES{1'b1}}))
        else $error("R5: global write missed a lane");

    p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe)
        else $error("R8: driver on with oe_n high");

    p_write_drive_off_r9: assert property (@(posedge clk) disable iff (rst)
        (|we_lanes) |=> !dq_oe)
        else $error("R9: driver on after write");

    p_snooze_hold_r10: assert property (@(posedge clk) disable iff (rst)
        snooze |=> $stable(dq_out))
        else $error("R10: read data changed in snooze");

    p_snooze_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
        snooze |-> (we_lanes == '0))
        else $error("R10: write during snooze");

    p_adsp_ce1_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (!snooze && ce1_n && adsc_n && !active) |-> (op == OP_NOP))
        else $error("R12: ignored strobe started an access");
endmodule

bind sbw_sram_ctl sbw_sram_ctl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .snooze   (snooze),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .gw_n     (gw_n),
    .oe_n     (oe_n),
    .active   (active),
    .p_start  (p_start),
    .op       (op),
    .we_lanes (we_lanes),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/sbw_sram_ctl_bench.sv
module sbw_sram_ctl_bench;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        snooze = 1'b0;
    logic        ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic        adsp_n = 1'b1, adsc_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic        oe_n = 1'b0;
    logic [31:0] dq_in = '0;
    logic [31:0] dq_out;
    logic        dq_oe;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_mem [DEPTH];
    logic [31:0] m_data = '0;
    logic        m_drv = 1'b0;
    logic        m_act = 1'b0;

    always #5 clk = ~clk;

    sbw_sram_ctl #(.AW(AW)) u_sbw_sram_ctl (
        .clk(clk), .rst(rst), .snooze(snooze), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bsel_n(bsel_n), .addr(addr), .oe_n(oe_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [31:0] init_word(input int i);
        return (i * 32'h0101_0101) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [3:0] exp_lanes();
        if (!gw_n) return 4'hF;
        if (!bwe_n) return ~bsel_n;
        return 4'h0;
    endfunction

    // Reference model of the per-edge decision, from the requirements.
    task automatic model_edge();
        logic sel, pv, cv, wr;
        logic [3:0] ln;
        if (snooze) return;
        sel = !ce1_n && ce2 && !ce3_n;
        pv  = !adsp_n && !ce1_n;
        cv  = !adsc_n;
        ln  = exp_lanes();
        wr  = |ln;
        if ((pv || cv) && !sel) begin
            m_act = 1'b0; m_drv = 1'b0;
        end else if (pv) begin
            m_act = 1'b1; m_drv = 1'b1; m_data = m_mem[addr];
        end else if (cv || m_act) begin
            m_act = 1'b1;
            if (wr) begin
                for (int i = 0; i < 4; i++)
                    if (ln[i]) m_mem[addr][8*i +: 8] = dq_in[8*i +: 8];
                m_drv = 1'b0;
            end else begin
                m_drv = 1'b1; m_data = m_mem[addr];
            end
        end else begin
            m_drv = 1'b0;
        end
    endtask

    task automatic compare(input string tag);
        tests++;
        if (dq_out !== m_data || dq_oe !== (m_drv && !oe_n)) begin
            fails++;
            $display("FAIL %s: dq_out=%h dq_oe=%b expected dq_out=%h dq_oe=%b",
                     tag, dq_out, dq_oe, m_data, m_drv && !oe_n);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle_in();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
        bsel_n = 4'hF; snooze = 1'b0; oe_n = 1'b0;
    endtask

    task automatic c_read(input int a, input string tag);
        idle_in(); adsc_n = 1'b0; addr = AW'(a);
        step(tag);
    endtask

    task automatic deselect(input string tag);
        idle_in(); adsc_n = 1'b0; ce2 = 1'b0;
        step(tag);
    endtask

    initial begin
        #(200000 * 10);
        fails++; tests++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R13 reset state");

        // Fill array through controller-strobe global writes.
        for (int i = 0; i < DEPTH; i++) begin
            idle_in(); adsc_n = 1'b0; gw_n = 1'b0; addr = AW'(i); dq_in = init_word(i);
            step("R4 init write");
        end
        deselect("R1 deselect after fill");

        c_read(5, "R7 read addr 5");
        c_read(6, "R4 controller read");

        oe_n = 1'b1; #1; compare("R8 oe_n high async");
        oe_n = 1'b0; #1; compare("R8 oe_n low again");

        // Processor start with write inputs active: still a read.
        idle_in(); adsp_n = 1'b0; gw_n = 1'b0; addr = 6'd9; dq_in = 32'hDEAD_BEEF;
        step("R2 processor start reads");
        idle_in(); gw_n = 1'b0; oe_n = 1'b0; addr = 6'd9; dq_in = 32'hCAFE_F00D;
        step("R9 driver off after delayed write");
        c_read(9, "R3 delayed write stored");

        idle_in(); adsc_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b1010; addr = 6'd12; dq_in = 32'h1122_3344;
        step("R6 byte lanes 0 and 2");
        c_read(12, "R6 readback");

        idle_in(); adsc_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; bsel_n = 4'hF; addr = 6'd13; dq_in = 32'h0BAD_CAFE;
        step("R5 global write overrides");
        c_read(13, "R5 readback");

        idle_in(); adsc_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'hF; addr = 6'd14; dq_in = 32'hFFFF_FFFF;
        step("R11 no selects is read");
        c_read(14, "R11 contents unchanged");

        idle_in(); adsc_n = 1'b0; ce2 = 1'b0; gw_n = 1'b0; addr = 6'd20; dq_in = 32'h1234_5678;
        step("R1 deselect drops write");
        idle_in(); ce1_n = 1'b1; adsp_n = 1'b0; addr = 6'd21;
        step("R12 adsp ignored with ce1_n high");
        c_read(20, "R1 contents unchanged");

        idle_in(); snooze = 1'b1; adsc_n = 1'b0; gw_n = 1'b0; addr = 6'd21; dq_in = 32'h7777_7777;
        step("R10 snooze holds outputs");
        c_read(21, "R10 array kept");

        // Constrained random mix.
        for (int n = 0; n < 4000; n++) begin
            ce1_n  = ($urandom % 8) == 0;
            ce2    = ($urandom % 8) != 0;
            ce3_n  = ($urandom % 8) == 0;
            adsp_n = ($urandom % 4) != 0;
            adsc_n = ($urandom % 4) != 0;
            gw_n   = ($urandom % 5) != 0;
            bwe_n  = ($urandom % 2) != 0;
            bsel_n = 4'($urandom);
            snooze = ($urandom % 16) == 0;
            oe_n   = ($urandom % 4) == 0;
            addr   = AW'($urandom);
            dq_in  = $urandom;
            step("R7 random traffic");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
    end
endmodule